// File: doc/BRIEF.md
# Oversampled Framed-Byte Receiver

This block recovers command frames from a serial line of hard-decided bits, each bit spread over four consecutive samples, one sample per clock. A frame opens with a long low run whose length must fall inside a window. It carries a sequence of ten-bit characters, each framed by a low start bit and a high stop bit. It closes with a character that is all zeros. Each data byte is written to an external buffer through a single-cycle write port, with an address equal to its position in the frame.

Framing faults put the receiver into a short hold-off. During the hold-off the line is ignored. The receiver then returns to hunting for a new frame. A software-set length limit bounds the buffer. The byte count of the last frame stays on its output until the next valid frame opening, and a one-cycle done pulse marks each non-empty frame. CRC checking and command decoding sit downstream.

Top module: `fbr_rx_top`

## Requirements
- R1: Each bit occupies four samples. The receiver takes a bit's value from its third sample, counted from the sample on which the low run or the start bit was first seen. A character sends its start bit (0) first, then the data byte least-significant bit first, then the stop bit (1).
- R2: A low sample while hunting begins a frame opening. It is accepted when a high bit follows at least 10 and at most 14 low bit-times. When it is accepted, byte_count_o clears to 0 on the following clock.
- R3: An opening that goes high after fewer than 10 low bit-times is a fault. So is one that reaches a 15th low bit-time. Neither writes a byte, and neither changes byte_count_o.
- R4: Between characters, up to 25 consecutive high samples are tolerated. The 26th is a fault. A low sample before that starts a character.
- R5: A character with stop bit 1 and start bit 0 produces one wr_en_o cycle. wr_data_o carries the data byte and wr_addr_o carries its index in the frame (0 first). byte_count_o then equals wr_addr_o + 1.
- R6: An all-zero character ends the frame. frame_done_o pulses high for exactly one clock when the frame holds at least one byte.
- R7: A frame that ends with no data byte produces no frame_done_o pulse, and byte_count_o reads 0.
- R8: Any other character (neither valid nor all zeros) is a fault. It writes nothing and gives no frame_done_o.
- R9: The byte that brings the count to max_len_i (capped at MAX_BYTES, and 1 or more) is still written. That is a fault, and no frame_done_o follows.
- R10: After a fault, the receiver ignores the line for 11 samples and then hunts again. An opening already low during the hold-off is only timed from the first sample after it.
- R11: byte_count_o holds its value between frames until the next accepted opening.
- R12: clear_i, sampled on a clock edge, returns the receiver to hunting with all counters at zero. The frame in progress then gives no frame_done_o.
- R13: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one line sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous return to hunting |
| sample_i | input | 1 | Hard-decided line sample |
| max_len_i | input | CNT_W | Buffer length limit in bytes |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | ADDR_W | Byte index within the frame |
| wr_data_o | output | 8 | Received data byte |
| byte_count_o | output | CNT_W | Bytes in current or last frame |
| frame_done_o | output | 1 | One-cycle pulse at end of a non-empty frame |

## Verification
The assertions assume that max_len_i does not change while a frame is in progress and stays at 1 or more. They also assume that a sample is presented on every clock. The stimulus sets the limit only while the line idles high between frames, and it drives every bit as four equal samples. Between scenarios the line is held high long enough that any hold-off or gap timeout has finished, so each scenario starts from the hunting state.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_OPEN,
    ST_GAP,
    ST_CHAR,
    ST_HOLD
  } rx_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fbr_char_shift.sv
module fbr_char_shift #(
  parameter int CHAR_BITS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       sample_i,
  input  logic       shift_en_i,
  input  logic       shift_clr_i,
  output logic       good_o,
  output logic       eof_o,
  output logic [7:0] data_o
);

  localparam int HELD_W = CHAR_BITS - 1;

  logic [HELD_W-1:0]    held_q;
  logic [CHAR_BITS-1:0] nxt;

  // value the character would have if this sample is its last bit
  assign nxt    = {sample_i, held_q};
  assign good_o = nxt[CHAR_BITS-1] & ~nxt[0];
  assign eof_o  = (nxt == '0);
  assign data_o = nxt[8:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (clear_i || shift_clr_i) begin
      held_q <= '0;
    end else if (shift_en_i) begin
      held_q <= nxt[CHAR_BITS-1:1];
    end
  end

endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int OSR        = 4,
  parameter int SAMPLE_POS = 2,
  parameter int OPEN_MIN   = 10,
  parameter int OPEN_MAX   = 14,
  parameter int GAP_MAX    = 25,
  parameter int HOLD_LEN   = 10,
  parameter int CHAR_BITS  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  input  logic char_good_i,
  input  logic char_eof_i,
  input  logic full_i,
  output logic shift_en_o,
  output logic shift_clr_o,
  output logic push_o,
  output logic frame_end_o,
  output logic open_ok_o
);

  localparam int RUN_W = $clog2(max2(max2(GAP_MAX, HOLD_LEN), OSR) + 2);
  localparam int BIT_W = $clog2(max2(OPEN_MAX, CHAR_BITS) + 2);

  localparam logic [RUN_W-1:0] POS_SMP  = RUN_W'(SAMPLE_POS);
  localparam logic [RUN_W-1:0] POS_WRAP = RUN_W'(OSR);
  localparam logic [RUN_W-1:0] GAP_LIM  = RUN_W'(GAP_MAX);
  localparam logic [RUN_W-1:0] HOLD_LIM = RUN_W'(HOLD_LEN);
  localparam logic [BIT_W-1:0] OPN_LO   = BIT_W'(OPEN_MIN);
  localparam logic [BIT_W-1:0] OPN_HI   = BIT_W'(OPEN_MAX);
  localparam logic [BIT_W-1:0] CHR_LEN  = BIT_W'(CHAR_BITS);

  rx_state_e        st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d, run_inc;
  logic [BIT_W-1:0] bits_q, bits_d, bits_inc;

  assign run_inc  = run_q + 1'b1;
  assign bits_inc = bits_q + 1'b1;

  always_comb begin
    st_d        = st_q;
    run_d       = run_q;
    bits_d      = bits_q;
    shift_en_o  = 1'b0;
    shift_clr_o = 1'b0;
    push_o      = 1'b0;
    frame_end_o = 1'b0;
    open_ok_o   = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (!sample_i) begin
          st_d   = ST_OPEN;
          run_d  = '0;
          bits_d = '0;
        end
      end
      ST_OPEN: begin
        run_d = run_inc;
        if (run_inc == POS_SMP) begin
          if (sample_i) begin
            run_d = '0;
            if (bits_q >= OPN_LO) begin
              st_d      = ST_GAP;
              bits_d    = '0;
              open_ok_o = 1'b1;
            end else begin
              st_d = ST_HOLD;
            end
          end else begin
            bits_d = bits_inc;
            if (bits_inc > OPN_HI) begin
              st_d  = ST_HOLD;
              run_d = '0;
            end
          end
        end else if (run_inc >= POS_WRAP) begin
          run_d = '0;
        end
      end
      ST_GAP: begin
        if (sample_i) begin
          run_d = run_inc;
          if (run_inc > GAP_LIM) begin
            st_d  = ST_HOLD;
            run_d = '0;
          end
        end else begin
          st_d        = ST_CHAR;
          run_d       = '0;
          bits_d      = '0;
          shift_clr_o = 1'b1;
        end
      end
      ST_CHAR: begin
        run_d = run_inc;
        if (run_inc == POS_SMP) begin
          shift_en_o = 1'b1;
          bits_d     = bits_inc;
          if (bits_inc == CHR_LEN) begin
            run_d  = '0;
            bits_d = '0;
            if (char_good_i) begin
              push_o = 1'b1;
              st_d   = full_i ? ST_HOLD : ST_GAP;
            end else if (char_eof_i) begin
              frame_end_o = 1'b1;
              st_d        = ST_HUNT;
            end else begin
              st_d = ST_HOLD;
            end
          end
        end else if (run_inc >= POS_WRAP) begin
          run_d = '0;
        end
      end
      ST_HOLD: begin
        run_d = run_inc;
        if (run_inc > HOLD_LIM) begin
          st_d  = ST_HUNT;
          run_d = '0;
        end
      end
      default: begin
        st_d  = ST_HUNT;
        run_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      run_q  <= '0;
      bits_q <= '0;
    end else if (clear_i) begin
      st_q   <= ST_HUNT;
      run_q  <= '0;
      bits_q <= '0;
    end else begin
      st_q   <= st_d;
      run_q  <= run_d;
      bits_q <= bits_d;
    end
  end

  a_r3_open_bits_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_OPEN |-> bits_q <= OPN_HI);

  a_r10_hold_exits_to_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |=> (st_q == ST_HOLD || st_q == ST_HUNT));

  a_r12_clear_to_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (st_q == ST_HUNT && run_q == '0 && bits_q == '0));

  a_r2_high_keeps_hunting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT && sample_i && !clear_i) |=> st_q == ST_HUNT);

endmodule

// File: rtl/fbr_byte_store.sv
module fbr_byte_store #(
  parameter int MAX_BYTES = 64,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int ADDR_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [7:0]        data_i,
  input  logic              open_ok_i,
  input  logic              frame_end_i,
  input  logic [CNT_W-1:0]  max_len_i,
  output logic              full_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [CNT_W-1:0]  byte_count_o,
  output logic              frame_done_o
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = (max_len_i > CAP) ? CAP : max_len_i;
  // this push makes the count reach the limit
  assign full_o = (cnt_q + 1'b1) >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      frame_done_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q        <= '0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      frame_done_o <= 1'b0;
    end else begin
      wr_en_o      <= push_i;
      frame_done_o <= frame_end_i && (cnt_q != '0);
      if (push_i) begin
        wr_addr_o <= cnt_q[ADDR_W-1:0];
        wr_data_o <= data_i;
        cnt_q     <= cnt_q + 1'b1;
      end
      if (open_ok_i) cnt_q <= '0;
    end
  end

  assign byte_count_o = cnt_q;

  a_r5_count_tracks_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> byte_count_o == CNT_W'(wr_addr_o) + 1'b1);

  a_r7_done_needs_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> byte_count_o != '0);

  a_r6_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r9_count_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_count_o <= CAP);

  a_r11_count_stable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !open_ok_i && !clear_i) |=> $stable(byte_count_o));

endmodule

// File: rtl/fbr_rx_top.sv
module fbr_rx_top #(
  parameter int MAX_BYTES  = 64,
  parameter int OSR        = 4,
  parameter int SAMPLE_POS = 2,
  parameter int OPEN_MIN   = 10,
  parameter int OPEN_MAX   = 14,
  parameter int GAP_MAX    = 25,
  parameter int HOLD_LEN   = 10,
  parameter int CHAR_BITS  = 10,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int ADDR_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [CNT_W-1:0]  max_len_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [CNT_W-1:0]  byte_count_o,
  output logic              frame_done_o
);

  logic shift_en, shift_clr, push, frame_end, open_ok;
  logic char_good, char_eof, full;
  logic [7:0] char_data;

  fbr_char_shift #(
    .CHAR_BITS (CHAR_BITS)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .sample_i    (sample_i),
    .shift_en_i  (shift_en),
    .shift_clr_i (shift_clr),
    .good_o      (char_good),
    .eof_o       (char_eof),
    .data_o      (char_data)
  );

  fbr_ctrl #(
    .OSR        (OSR),
    .SAMPLE_POS (SAMPLE_POS),
    .OPEN_MIN   (OPEN_MIN),
    .OPEN_MAX   (OPEN_MAX),
    .GAP_MAX    (GAP_MAX),
    .HOLD_LEN   (HOLD_LEN),
    .CHAR_BITS  (CHAR_BITS)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .sample_i    (sample_i),
    .char_good_i (char_good),
    .char_eof_i  (char_eof),
    .full_i      (full),
    .shift_en_o  (shift_en),
    .shift_clr_o (shift_clr),
    .push_o      (push),
    .frame_end_o (frame_end),
    .open_ok_o   (open_ok)
  );

  fbr_byte_store #(
    .MAX_BYTES (MAX_BYTES),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .push_i       (push),
    .data_i       (char_data),
    .open_ok_i    (open_ok),
    .frame_end_i  (frame_end),
    .max_len_i    (max_len_i),
    .full_o       (full),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .byte_count_o (byte_count_o),
    .frame_done_o (frame_done_o)
  );

endmodule

// File: tb/fbr_rx_top_bench.sv
module fbr_rx_top_bench;

  localparam int MAX_BYTES = 64;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int ADDR_W    = $clog2(MAX_BYTES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clear = 1'b0;
  logic              sample = 1'b1;
  logic [CNT_W-1:0]  max_len = CNT_W'(MAX_BYTES);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [CNT_W-1:0]  byte_count;
  logic              frame_done;

  int checks = 0;
  int errors = 0;
  int wr_total = 0;
  int done_total = 0;
  int wr_base = 0;
  int done_base = 0;
  logic [7:0] mem [MAX_BYTES];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fbr_rx_top #(.MAX_BYTES(MAX_BYTES)) u_fbr_rx_top (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .clear_i      (clear),
    .sample_i     (sample),
    .max_len_i    (max_len),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .byte_count_o (byte_count),
    .frame_done_o (frame_done)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_total <= wr_total + 1;
    end
    if (frame_done) done_total <= done_total + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    repeat (4) begin
      @(negedge clk);
      sample = b;
    end
  endtask

  task automatic drive_run(input logic b, input int n);
    for (int i = 0; i < n; i++) drive_bit(b);
  endtask

  task automatic drive_char(input logic [7:0] d, input logic stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(stop);
  endtask

  task automatic mark();
    drive_run(1'b1, 16);
    wr_base = wr_total;
    done_base = done_total;
  endtask

  task automatic frame_open(input int zeros);
    drive_run(1'b0, zeros);
    drive_run(1'b1, 2);
  endtask

  task automatic t_reset();
    chk(wr_en == 0 && frame_done == 0, "R13 strobes", int'(wr_en) + int'(frame_done), 0);
    chk(byte_count == 0 && wr_addr == 0 && wr_data == 0, "R13 data", int'(byte_count), 0);
  endtask

  task automatic t_normal();
    mark();
    frame_open(10);
    drive_char(8'h05, 1'b1);
    drive_run(1'b1, 1);
    drive_char(8'h00, 1'b1);
    drive_char(8'hA7, 1'b1);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 4);
    chk(wr_total - wr_base == 3, "R5 write count", wr_total - wr_base, 3);
    chk(mem[0] == 8'h05 && mem[1] == 8'h00 && mem[2] == 8'hA7, "R1 bytes",
        int'(mem[2]), 8'hA7);
    chk(done_total - done_base == 1, "R6 one done pulse", done_total - done_base, 1);
    chk(byte_count == 3, "R5 count", int'(byte_count), 3);
    drive_run(1'b1, 20);
    chk(byte_count == 3, "R11 count held", int'(byte_count), 3);
  endtask

  task automatic t_open_edges();
    mark();
    frame_open(14);
    drive_char(8'h3C, 1'b1);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 4);
    chk(done_total - done_base == 1 && mem[0] == 8'h3C, "R2 fourteen-bit opening",
        done_total - done_base, 1);
    mark();
    frame_open(8);
    drive_run(1'b1, 10);
    chk(byte_count == 1, "R3 short opening keeps count", int'(byte_count), 1);
    mark();
    drive_run(1'b0, 16);
    drive_run(1'b1, 10);
    chk(byte_count == 1 && wr_total == wr_base, "R3 long opening rejected",
        int'(byte_count), 1);
  endtask

  task automatic t_gap();
    mark();
    drive_run(1'b0, 10);
    drive_run(1'b1, 7);
    drive_char(8'h81, 1'b1);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 4);
    chk(done_total - done_base == 1 && mem[0] == 8'h81, "R4 25 high samples ok",
        done_total - done_base, 1);
    mark();
    drive_run(1'b0, 10);
    drive_run(1'b1, 8);
    drive_char(8'h81, 1'b1);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 16);
    chk(done_total == done_base && wr_total == wr_base, "R4 26 high samples fault",
        wr_total - wr_base, 0);
  endtask

  task automatic t_bad_char();
    mark();
    frame_open(11);
    drive_char(8'h33, 1'b1);
    drive_char(8'h01, 1'b0);
    drive_run(1'b1, 16);
    chk(wr_total - wr_base == 1 && done_total == done_base, "R8 bad stop bit",
        done_total - done_base, 0);
  endtask

  task automatic t_max_len();
    max_len = CNT_W'(2);
    mark();
    frame_open(10);
    drive_char(8'h11, 1'b1);
    drive_char(8'h22, 1'b1);
    drive_char(8'h5A, 1'b1);
    drive_run(1'b1, 16);
    chk(wr_total - wr_base == 2 && mem[1] == 8'h22, "R9 writes up to limit",
        wr_total - wr_base, 2);
    chk(byte_count == 2 && done_total == done_base, "R9 count at limit no done",
        int'(byte_count), 2);
    max_len = CNT_W'(MAX_BYTES);
  endtask

  task automatic t_empty();
    mark();
    frame_open(12);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 4);
    chk(done_total == done_base, "R7 empty frame no done", done_total - done_base, 0);
    chk(byte_count == 0, "R7 empty frame count", int'(byte_count), 0);
  endtask

  task automatic t_hold();
    mark();
    frame_open(14);
    drive_char(8'h6E, 1'b1);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 4);
    mark();
    // short opening faults on the third sample of its first high bit
    drive_run(1'b0, 8);
    drive_bit(1'b1);
    drive_run(1'b0, 10);
    drive_run(1'b1, 2);
    drive_char(8'h44, 1'b1);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 16);
    chk(wr_total == wr_base && done_total == done_base, "R10 hold eats opening",
        wr_total - wr_base, 0);
    mark();
    drive_run(1'b0, 8);
    drive_bit(1'b1);
    drive_run(1'b0, 13);
    drive_run(1'b1, 2);
    drive_char(8'h44, 1'b1);
    drive_char(8'h00, 1'b0);
    drive_run(1'b1, 4);
    chk(done_total - done_base == 1 && mem[0] == 8'h44, "R10 resync after hold",
        done_total - done_base, 1);
  endtask

  task automatic t_reopen();
    chk(byte_count == 1, "R11 count before reopen", int'(byte_count), 1);
    mark();
    drive_run(1'b0, 10);
    drive_bit(1'b1);
    chk(byte_count == 0, "R2 count cleared by opening", int'(byte_count), 0);
    drive_run(1'b1, 16);
  endtask

  task automatic t_clear();
    mark();
    frame_open(10);
    drive_char(8'h9B, 1'b1);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    drive_run(1'b1, 16);
    chk(byte_count == 0 && done_total == done_base, "R12 clear mid-frame",
        int'(byte_count), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_normal();
    t_open_edges();
    t_gap();
    t_bad_char();
    t_max_len();
    t_empty();
    t_hold();
    t_reopen();
    t_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule